// File: doc/BRIEF.md
# Exposure/Readout Field Sequencer

This block paces a still-capture cycle for a CCD timing generator by counting vertical-drive falling edges. Software programs a field total, a start delay and two mask lengths, then pulses an action write. The sequence begins at the next vertical-drive edge. At that edge all configuration inputs are captured, so later changes to them wait for the next sequence. From then on the block asserts a sensor-gate mask and a substrate-clear mask, each over its own window of fields, until the programmed total of fields has passed.

During the same cycle the block drives three general-purpose levels: a flash strobe, a mechanical shutter and a substrate bias. Each switches at a programmed field/line/pixel position. Line and pixel positions come from internal counters kept in step with the horizontal and vertical sync edges. When the cycle completes, every output returns to its idle level.

Top module: `expo_field_seq`

## Requirements
- R1: Out of reset, and whenever no sequence runs, `vsg_mask`=0, `subck_mask`=0, `gp_strobe`=0, `gp_shutter`=1, `gp_vsub`=0 and `busy`=0.
- R2: An `act_wr` pulse while `busy`=0 sets `busy` from the next cycle. No field is counted and no mask asserts until a later `vd_fall`.
- R3: The `vd_fall` that starts the sequence captures every `cfg_*`, `strb_*`, `shut_*` and `vsub_*` input and makes it field 0. Changing these inputs afterwards has no effect on the running sequence.
- R4: Each further `vd_fall` advances the field index. The `vd_fall` that ends field `cfg_total`-1 ends the sequence and clears `busy` (a total of 0 behaves as 1).
- R5: `vsg_mask` is 1 exactly in fields f with `cfg_delay` <= f < `cfg_delay`+`cfg_sg_len`, and changes only in the cycle after a `vd_fall`.
- R6: `subck_mask` is 1 exactly in fields f with `cfg_delay` <= f < `cfg_delay`+`cfg_sc_len`, and changes only in the cycle after a `vd_fall`.
- R7: A mask window that reaches past the last field is cut off at the terminal `vd_fall`.
- R8: The pixel position is 0 in the cycle after an `hd_fall` and rises by one per clock. The line position is 0 after a `vd_fall` and rises by one per `hd_fall` that does not coincide with a `vd_fall`. A GP output changes in the cycle after the one where field, line and pixel all equal its programmed triple.
- R9: `gp_strobe` goes to 1 at its on-position and to 0 at its off-position. If both positions are equal, off wins.
- R10: `gp_shutter` goes from 1 to 0 at its position, and `gp_vsub` goes from 0 to 1 at its position.
- R11: In the cycle after the terminal `vd_fall`, the strobe is 0, the shutter is 1 and the substrate bias is 0, whatever positions were reached.
- R12: `act_wr` while `busy`=1 is ignored, including a pulse in the same cycle as the terminal `vd_fall`. No new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| vd_fall | input | 1 | one-cycle vertical-drive falling-edge strobe |
| hd_fall | input | 1 | one-cycle horizontal-drive falling-edge strobe |
| act_wr | input | 1 | action write: arms a sequence |
| cfg_total | input | FW | fields in the whole cycle |
| cfg_delay | input | FW | fields before either mask starts |
| cfg_sg_len | input | FW | sensor-gate mask length in fields |
| cfg_sc_len | input | FW | substrate-clear mask length in fields |
| strb_on_fld | input | FW | strobe on field |
| strb_on_line | input | LW | strobe on line |
| strb_on_pix | input | PW | strobe on pixel |
| strb_off_fld | input | FW | strobe off field |
| strb_off_line | input | LW | strobe off line |
| strb_off_pix | input | PW | strobe off pixel |
| shut_fld | input | FW | shutter close field |
| shut_line | input | LW | shutter close line |
| shut_pix | input | PW | shutter close pixel |
| vsub_fld | input | FW | substrate bias on field |
| vsub_line | input | LW | substrate bias on line |
| vsub_pix | input | PW | substrate bias on pixel |
| busy | output | 1 | armed or running |
| vsg_mask | output | 1 | suppress sensor-gate pulses |
| subck_mask | output | 1 | suppress substrate-clear pulses |
| gp_strobe | output | 1 | flash strobe level |
| gp_shutter | output | 1 | mechanical shutter level (1 = open) |
| gp_vsub | output | 1 | substrate bias level |

## Verification
Two events can land in the same cycle: the terminal vertical-drive edge and a new action write. Otherwise that edge could both close one sequence and arm the next. The bench pulses `act_wr` together with the terminal `vd_fall`, then runs a whole extra field. `busy` and both masks must stay at 0 there. A second coincidence, equal strobe on and off positions, is provoked in another scenario. It is judged by the strobe staying low for the whole sequence.

// File: rtl/expo_field_seq.sv
module expo_field_seq #(
  parameter int FW = 4,
  parameter int LW = 10,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vd_fall,
  input  logic          hd_fall,
  input  logic          act_wr,
  input  logic [FW-1:0] cfg_total,
  input  logic [FW-1:0] cfg_delay,
  input  logic [FW-1:0] cfg_sg_len,
  input  logic [FW-1:0] cfg_sc_len,
  input  logic [FW-1:0] strb_on_fld,
  input  logic [LW-1:0] strb_on_line,
  input  logic [PW-1:0] strb_on_pix,
  input  logic [FW-1:0] strb_off_fld,
  input  logic [LW-1:0] strb_off_line,
  input  logic [PW-1:0] strb_off_pix,
  input  logic [FW-1:0] shut_fld,
  input  logic [LW-1:0] shut_line,
  input  logic [PW-1:0] shut_pix,
  input  logic [FW-1:0] vsub_fld,
  input  logic [LW-1:0] vsub_line,
  input  logic [PW-1:0] vsub_pix,
  output logic          busy,
  output logic          vsg_mask,
  output logic          subck_mask,
  output logic          gp_strobe,
  output logic          gp_shutter,
  output logic          gp_vsub
);

  localparam int XW = FW + 1;
  localparam int NT = 4;
  localparam int POSW = FW + LW + PW;

  logic          armed, running;
  logic [FW-1:0] fld;
  logic [LW-1:0] line_cnt;
  logic [PW-1:0] pix_cnt;
  logic [FW-1:0] a_total, a_delay, a_sg, a_sc;
  logic [POSW-1:0] a_pos [NT];
  logic [POSW-1:0] cfg_pos [NT];
  logic [NT-1:0]   hit;
  logic          last_fld, end_now, start_now;
  logic [XW-1:0] sg_end, sc_end, fld_x;

  assign cfg_pos[0] = {strb_on_fld,  strb_on_line,  strb_on_pix};
  assign cfg_pos[1] = {strb_off_fld, strb_off_line, strb_off_pix};
  assign cfg_pos[2] = {shut_fld,     shut_line,     shut_pix};
  assign cfg_pos[3] = {vsub_fld,     vsub_line,     vsub_pix};

  assign fld_x     = {1'b0, fld};
  assign last_fld  = (fld_x + XW'(1)) >= {1'b0, a_total};
  assign start_now = vd_fall && armed;
  assign end_now   = vd_fall && running && last_fld;
  assign busy      = armed | running;

  assign sg_end     = {1'b0, a_delay} + {1'b0, a_sg};
  assign sc_end     = {1'b0, a_delay} + {1'b0, a_sc};
  assign vsg_mask   = running && (fld >= a_delay) && (fld_x < sg_end);
  assign subck_mask = running && (fld >= a_delay) && (fld_x < sc_end);

  for (genvar i = 0; i < NT; i++) begin : g_hit
    assign hit[i] = running && (a_pos[i] == {fld, line_cnt, pix_cnt});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      running <= 1'b0;
      fld     <= '0;
      a_total <= '0;
      a_delay <= '0;
      a_sg    <= '0;
      a_sc    <= '0;
      for (int i = 0; i < NT; i++) a_pos[i] <= '0;
    end else begin
      if (act_wr && !busy) armed <= 1'b1;
      if (start_now) begin
        armed   <= 1'b0;
        running <= 1'b1;
        fld     <= '0;
        a_total <= cfg_total;
        a_delay <= cfg_delay;
        a_sg    <= cfg_sg_len;
        a_sc    <= cfg_sc_len;
        for (int i = 0; i < NT; i++) a_pos[i] <= cfg_pos[i];
      end else if (vd_fall && running) begin
        if (last_fld) running <= 1'b0;
        else fld <= fld + FW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      pix_cnt  <= '0;
    end else begin
      pix_cnt <= hd_fall ? '0 : pix_cnt + PW'(1);
      if (vd_fall) line_cnt <= '0;
      else if (hd_fall) line_cnt <= line_cnt + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !running || end_now) begin
      gp_strobe  <= 1'b0;
      gp_shutter <= 1'b1;
      gp_vsub    <= 1'b0;
    end else begin
      if (hit[1]) gp_strobe <= 1'b0;
      else if (hit[0]) gp_strobe <= 1'b1;
      if (hit[2]) gp_shutter <= 1'b0;
      if (hit[3]) gp_vsub <= 1'b1;
    end
  end

  a_r2_arm_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wr && !busy) |=> busy);
  a_r4_start_on_vd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(vd_fall));
  a_r5_sg_moves_on_vd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsg_mask) |-> $past(vd_fall));
  a_r6_sc_moves_on_vd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(subck_mask) |-> $past(vd_fall));
  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vd_fall) |=> busy);
  a_r11_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (gp_shutter && !gp_strobe && !gp_vsub));

endmodule

// File: tb/sim_expo_field_seq.sv
module sim_expo_field_seq;
  localparam int FW = 4, LW = 10, PW = 12;
  localparam int LPF = 4, PPL = 16;

  logic clk = 0, rst_n = 0, vd_fall = 0, hd_fall = 0, act_wr = 0;
  logic [FW-1:0] cfg_total = 0, cfg_delay = 0, cfg_sg_len = 0, cfg_sc_len = 0;
  logic [FW-1:0] strb_on_fld = 0, strb_off_fld = 0, shut_fld = 0, vsub_fld = 0;
  logic [LW-1:0] strb_on_line = 0, strb_off_line = 0, shut_line = 0, vsub_line = 0;
  logic [PW-1:0] strb_on_pix = 0, strb_off_pix = 0, shut_pix = 0, vsub_pix = 0;
  logic busy, vsg_mask, subck_mask, gp_strobe, gp_shutter, gp_vsub;
  int errors = 0, checks = 0;
  bit done = 0;
  int on_i, off_i, sh_i, vs_i;

  always #4 clk = ~clk;

  expo_field_seq #(.FW(FW), .LW(LW), .PW(PW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit h, input bit a);
    vd_fall = v; hd_fall = h; act_wr = a;
    @(negedge clk);
    vd_fall = 0; hd_fall = 0; act_wr = 0;
  endtask

  function automatic int pidx(input int f, input int l, input int p);
    return (f * LPF + l) * PPL + p;
  endfunction

  task automatic set_gp(input int onf, onl, onp, offf, offl, offp, shf, shl, shp, vf, vl, vp);
    strb_on_fld = FW'(onf); strb_on_line = LW'(onl); strb_on_pix = PW'(onp);
    strb_off_fld = FW'(offf); strb_off_line = LW'(offl); strb_off_pix = PW'(offp);
    shut_fld = FW'(shf); shut_line = LW'(shl); shut_pix = PW'(shp);
    vsub_fld = FW'(vf); vsub_line = LW'(vl); vsub_pix = PW'(vp);
    on_i = pidx(onf, onl, onp); off_i = pidx(offf, offl, offp);
    sh_i = pidx(shf, shl, shp); vs_i = pidx(vf, vl, vp);
  endtask

  task automatic check_idle(input string req);
    chk(!vsg_mask && !subck_mask, {req, " masks idle"}, {vsg_mask, subck_mask}, 0);
    chk(!gp_strobe && gp_shutter && !gp_vsub, {req, " gp idle"},
        {gp_strobe, gp_shutter, gp_vsub}, 3'b010);
    chk(!busy, {req, " busy clear"}, busy, 0);
  endtask

  // R8 R9 R10: compare GP levels against the position model for a whole field
  task automatic field_body(input int f);
    int bad = 0, ga = 0, ge = 0;
    for (int l = 0; l < LPF; l++) begin
      for (int p = 0; p < PPL; p++) begin
        int idx, es, esh, ev;
        if (l == 0 && p == 0) begin
          idx = pidx(f, 0, 0);
        end else begin
          step(0, p == 0, 0);
          idx = pidx(f, l, p);
        end
        es  = (idx > on_i) && !((idx > off_i) && (off_i >= on_i));
        esh = !(idx > sh_i);
        ev  = idx > vs_i;
        if (gp_strobe !== es[0] || gp_shutter !== esh[0] || gp_vsub !== ev[0]) begin
          if (bad == 0) begin
            ga = {gp_strobe, gp_shutter, gp_vsub}; ge = {es[0], esh[0], ev[0]};
          end
          bad++;
        end
      end
    end
    chk(bad == 0, $sformatf("R8 R9 R10 gp levels field %0d", f), ga, ge);
  endtask

  task automatic run_seq(input int tot, dly, sg, sc, input bit poke);
    int eff = (tot == 0) ? 1 : tot;
    cfg_total = FW'(tot); cfg_delay = FW'(dly); cfg_sg_len = FW'(sg); cfg_sc_len = FW'(sc);
    step(0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    chk(busy, "R2 armed busy", busy, 1);
    chk(!vsg_mask && !subck_mask, "R2 no mask before VD", {vsg_mask, subck_mask}, 0);
    for (int f = 0; f < eff; f++) begin
      bit es = (f >= dly) && (f < dly + sg);
      bit ec = (f >= dly) && (f < dly + sc);
      step(1, 1, 0);
      chk(vsg_mask == es, $sformatf("R5 R7 sg mask field %0d", f), vsg_mask, es);
      chk(subck_mask == ec, $sformatf("R6 R7 sc mask field %0d", f), subck_mask, ec);
      chk(busy, $sformatf("R4 busy field %0d", f), busy, 1);
      if (poke && f == 0) begin
        // R3 R12: captured config must not move, write must be ignored
        cfg_delay = 0; cfg_sg_len = 7; cfg_sc_len = 7; cfg_total = 9;
        step(0, 0, 1);
        field_body_rest(f);
      end else begin
        field_body(f);
      end
    end
    step(1, 1, poke);
    check_idle("R4 R11 end");
    if (poke) begin
      step(1, 1, 0);
      for (int i = 0; i < 20; i++) step(0, 0, 0);
      chk(!busy && !vsg_mask && !subck_mask, "R12 no restart",
          {busy, vsg_mask, subck_mask}, 0);
    end
  endtask

  // field 0 of the poke run: one step already taken, GP set far away
  task automatic field_body_rest(input int f);
    for (int i = 2; i < LPF * PPL; i++) step(0, (i % PPL) == 0, 0);
    chk(vsg_mask == 0 && subck_mask == 0, $sformatf("R3 captured delay field %0d", f),
        {vsg_mask, subck_mask}, 0);
  endtask

  task automatic t_reset;
    check_idle("R1 reset");
  endtask

  task automatic t_reference;
    set_gp(1, 1, 2, 1, 2, 5, 1, 3, 7, 1, 0, 3);
    run_seq(5, 1, 1, 4, 0);
  endtask

  task automatic t_truncate;
    set_gp(2, 1, 0, 9, 0, 0, 2, 3, 15, 0, 0, 0);
    run_seq(3, 1, 5, 9, 0);
  endtask

  task automatic t_same_pos;
    set_gp(0, 2, 4, 0, 2, 4, 1, 0, 0, 1, 3, 15);
    run_seq(2, 0, 2, 1, 0);
  endtask

  task automatic t_zero_total;
    set_gp(0, 0, 0, 0, 3, 0, 0, 1, 1, 0, 2, 2);
    run_seq(0, 0, 1, 1, 0);
  endtask

  task automatic t_ignore;
    set_gp(9, 0, 0, 9, 0, 0, 9, 0, 0, 9, 0, 0);
    run_seq(3, 1, 1, 2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reference();
    t_truncate();
    t_same_pos();
    t_zero_total();
    t_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule